// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic read-modify-write on a single-port data memory. A caller presents a base address, a signed 16-bit displacement, a source operand, a comparison operand (the value of register zero), a two-bit access size and a 32-bit operation code, then pulses `start`. The unit reads the addressed location and computes the new value. It writes the new value back unless a compare-and-swap finds a mismatch. It then pulses `done` for one cycle. In that cycle it can also present the old memory contents for a register write-back.

The supported operations are add, OR, AND and XOR, each with an optional return of the old value. There is also swap, and compare-and-swap against register zero, at 32-bit and 64-bit width. Anything else is rejected with `illegal` before any memory traffic. The memory side uses a request/ready handshake for both accesses and a separate valid strobe for read data. The unit owns the memory from its read until its write completes.

Top module: `amo_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `illegal`, `mem_req` and both write-back enables are low.
- R2: The memory address of both accesses is `base_addr` plus `offset` sign-extended to 64 bits.
- R3: With `op_code[7:4]` equal to 0x0, 0x4, 0x5 or 0xA, the stored value is the old value plus, OR, AND or XOR the source operand.
- R4: For those four operations, `op_code[0]` set requests the old value. `done` then comes with `wb_src_en` high and `wb_data` equal to the old value. With the bit clear, no write-back enable rises.
- R5: Code 0xE1 stores the source operand and returns the old value through `wb_src_en`/`wb_data`.
- R6: Code 0xF1 compares register zero with the old value. On a match it stores the source operand. On a mismatch it issues no write request. In both cases `done` comes with `wb_r0_en` high and `wb_data` equal to the old value.
- R7: `op_size` 0 selects a 32-bit access and 3 selects a 64-bit access. `mem_wide` is high only for 64-bit accesses. A 32-bit access uses the low 32 bits of the operands and of the memory data, writes zero in `mem_wdata[63:32]`, and returns the old value zero-extended.
- R8: `op_size` 1 or 2 is rejected. So is code 0xE0 or 0xF0 without bit 0, any other value of `op_code[7:4]`, any set bit in `op_code[3:1]` and any set bit in `op_code[31:8]`. A rejected operation gives `done` and `illegal` together in the cycle after acceptance, with no memory request.
- R9: The unit issues a read, then a write. Each request is held with a stable address until `mem_ready`. Read data is taken on `mem_rvalid`, which may arrive in the acceptance cycle or later.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `start` is ignored while `busy` is high. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base_addr | input | 64 | Base register value |
| offset | input | 16 | Signed displacement |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register-zero value for compare |
| op_size | input | 2 | 0 word, 1 half, 2 byte, 3 doubleword |
| op_code | input | 32 | Operation immediate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Rejected operation, with `done` |
| wb_src_en | output | 1 | Write `wb_data` to the source register |
| wb_r0_en | output | 1 | Write `wb_data` to register zero |
| wb_data | output | 64 | Old memory value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Request is 64-bit |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
Read acceptance and read data can fall in the same cycle: a zero-latency memory raises `mem_ready` and `mem_rvalid` together. A slow memory instead stalls the acceptance two cycles and returns data one cycle later. Every operation vector runs under both memory behaviours. Each run is judged on the final memory word, the accepted address and width, the counts of read and write acceptances, and the write-back in the `done` cycle. A second `start` held across a busy interval must not produce a second write.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int XLEN = 64,
  parameter int OFFW = 16,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] base_addr,
  input  logic [OFFW-1:0] offset,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] r0_val,
  input  logic [1:0]      op_size,
  input  logic [IMMW-1:0] op_code,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            wb_src_en,
  output logic            wb_r0_en,
  output logic [XLEN-1:0] wb_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_wide,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam int HALF = XLEN / 2;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MOD, S_WRITE, S_DONE} state_t;
  state_t state;

  logic [XLEN-1:0] addr_q, src_q, r0_q, old_q, new_q;
  logic [3:0]      op_q;
  logic            wide_q, fetch_q, acc_q, ill_q;

  logic [3:0] code;
  logic       is_simple, is_cplx, rsv_bits, size_ok, legal;
  assign code      = op_code[7:4];
  assign is_simple = (code == 4'h0) || (code == 4'h4) || (code == 4'h5) || (code == 4'hA);
  assign is_cplx   = (code == 4'hE) || (code == 4'hF);
  assign rsv_bits  = (op_code[IMMW-1:8] != '0) || (op_code[3:1] != '0);
  assign size_ok   = (op_size == 2'd0) || (op_size == 2'd3);
  assign legal     = size_ok && !rsv_bits && (is_simple || (is_cplx && op_code[0]));

  function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic w);
    return w ? v : {{(XLEN-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  logic [XLEN-1:0] src_m, r0_m, alu;
  logic            is_cas, match;
  assign src_m  = narrow(src_q, wide_q);
  assign r0_m   = narrow(r0_q, wide_q);
  assign is_cas = (op_q == 4'hF);
  assign match  = (old_q == r0_m);

  always_comb begin
    case (op_q)
      4'h4:        alu = old_q | src_m;
      4'h5:        alu = old_q & src_m;
      4'hA:        alu = old_q ^ src_m;
      4'hE, 4'hF:  alu = src_m;
      default:     alu = old_q + src_m;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
      op_q    <= '0;
      wide_q  <= 1'b0;
      fetch_q <= 1'b0;
      acc_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q  <= base_addr + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
          src_q   <= src_val;
          r0_q    <= r0_val;
          op_q    <= code;
          wide_q  <= (op_size == 2'd3);
          fetch_q <= op_code[0];
          acc_q   <= 1'b0;
          ill_q   <= !legal;
          state   <= legal ? S_READ : S_DONE;
        end
        S_READ: begin
          if (mem_ready) acc_q <= 1'b1;
          if (mem_rvalid) begin
            old_q <= narrow(mem_rdata, wide_q);
            state <= S_MOD;
          end
        end
        S_MOD: begin
          new_q <= narrow(alu, wide_q);
          state <= (is_cas && !match) ? S_DONE : S_WRITE;
        end
        S_WRITE: if (mem_ready) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign illegal   = done && ill_q;
  assign wb_src_en = done && !ill_q && fetch_q && !is_cas;
  assign wb_r0_en  = done && !ill_q && is_cas;
  assign wb_data   = old_q;
  assign mem_req   = ((state == S_READ) && !acc_q) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_wide  = wide_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;

  p_reject_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !legal) |=> (done && illegal && !mem_req));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_wb_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_src_en && wb_r0_en));
  p_wb_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_src_en || wb_r0_en) |-> (done && !illegal));
  p_word_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wide) |-> (mem_wdata[XLEN-1:HALF] == '0));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_read_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && legal) |=> (mem_req && !mem_we));
endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start;
  logic [63:0] base_addr, src_val, r0_val;
  logic [15:0] offset;
  logic [1:0]  op_size;
  logic [31:0] op_code;
  logic        busy, done, illegal, wb_src_en, wb_r0_en;
  logic [63:0] wb_data, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_wide, mem_ready, mem_rvalid;

  amo_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .offset(offset),
    .src_val(src_val), .r0_val(r0_val), .op_size(op_size), .op_code(op_code),
    .busy(busy), .done(done), .illegal(illegal), .wb_src_en(wb_src_en),
    .wb_r0_en(wb_r0_en), .wb_data(wb_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  // memory model
  logic [63:0] mem [16];
  logic        slow, rv_q, clr, pl_en;
  logic [1:0]  stall;
  logic [3:0]  pl_idx;
  logic [63:0] pl_data, last_addr;
  logic        last_wide;
  int          rd_cnt, wr_cnt;

  assign mem_ready  = mem_req && (!slow || stall == 2'd2);
  assign mem_rvalid = slow ? rv_q : (mem_ready && !mem_we);
  assign mem_rdata  = mem[mem_addr[6:3]];

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    if (mem_req && mem_ready && mem_we) begin
      if (mem_wide) mem[mem_addr[6:3]] <= mem_wdata;
      else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
    end
    rv_q  <= slow && mem_req && mem_ready && !mem_we;
    stall <= (mem_req && !mem_ready) ? stall + 2'd1 : 2'd0;
    if (clr) begin
      rd_cnt <= 0; wr_cnt <= 0;
    end else if (mem_req && mem_ready) begin
      if (mem_we) wr_cnt <= wr_cnt + 1; else rd_cnt <= rd_cnt + 1;
      last_addr <= mem_addr;
      last_wide <= mem_wide;
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] imm;
    logic [1:0]  sz;
    logic [63:0] base;
    logic [15:0] off;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] min;
    logic [63:0] mout;
    logic        wsrc;
    logic        wr0;
    logic [63:0] wbd;
    logic        ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t V [NV] = '{
    '{32'h00, 2'd3, 64'h40, 16'h0008, 64'h3, 64'h0, 64'h5, 64'h8, 1'b0, 1'b0, 64'h0, 1'b0},
    '{32'h01, 2'd0, 64'h40, 16'h0008, 64'h1_0000_0002, 64'h0, 64'hAAAA_BBBB_FFFF_FFFF, 64'hAAAA_BBBB_0000_0001, 1'b1, 1'b0, 64'hFFFF_FFFF, 1'b0},
    '{32'h41, 2'd3, 64'h40, 16'h0008, 64'h0F, 64'h0, 64'hF0, 64'hFF, 1'b1, 1'b0, 64'hF0, 1'b0},
    '{32'h50, 2'd0, 64'h40, 16'h0008, 64'hF0F, 64'h0, 64'h1234_5678_FFFF_00FF, 64'h1234_5678_0000_000F, 1'b0, 1'b0, 64'h0, 1'b0},
    '{32'hA1, 2'd3, 64'h40, 16'h0008, 64'h0FF0, 64'h0, 64'hFF00, 64'hF0F0, 1'b1, 1'b0, 64'hFF00, 1'b0},
    '{32'hE1, 2'd3, 64'h40, 16'h0008, 64'h2222, 64'h0, 64'h1111, 64'h2222, 1'b1, 1'b0, 64'h1111, 1'b0},
    '{32'hF1, 2'd3, 64'h40, 16'h0008, 64'h9, 64'h7, 64'h7, 64'h9, 1'b0, 1'b1, 64'h7, 1'b0},
    '{32'hF1, 2'd3, 64'h40, 16'h0008, 64'h9, 64'h6, 64'h7, 64'h7, 1'b0, 1'b1, 64'h7, 1'b0},
    '{32'hF1, 2'd0, 64'h40, 16'h0008, 64'h77, 64'hBEEF_0000_0000_0005, 64'hDEAD_0000_0000_0005, 64'hDEAD_0000_0000_0077, 1'b0, 1'b1, 64'h5, 1'b0},
    '{32'h00, 2'd3, 64'h50, 16'hFFF8, 64'h10, 64'h0, 64'h20, 64'h30, 1'b0, 1'b0, 64'h0, 1'b0},
    '{32'hE1, 2'd0, 64'h40, 16'h0008, 64'hFFFF_FFFF_1234_5678, 64'h0, 64'h9999_9999_8888_8888, 64'h9999_9999_1234_5678, 1'b1, 1'b0, 64'h8888_8888, 1'b0},
    '{32'hE0, 2'd3, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1},
    '{32'h10, 2'd3, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1},
    '{32'h00, 2'd1, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1},
    '{32'h01, 2'd2, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1},
    '{32'h03, 2'd3, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1},
    '{32'h100, 2'd0, 64'h40, 16'h0008, 64'h1, 64'h0, 64'h55, 64'h55, 1'b0, 1'b0, 64'h0, 1'b1}
  };

  task automatic preload(input logic [63:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = 4'd9; pl_data = d; clr = 1'b1;
    @(negedge clk);
    pl_en = 1'b0; clr = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk("R10 done timeout", 64'd0, 64'd1);
  endtask

  task automatic run_vec(input vec_t v);
    bit ok;
    bit exp_wr;
    preload(v.min);
    base_addr = v.base; offset = v.off; src_val = v.src; r0_val = v.r0;
    op_size = v.sz; op_code = v.imm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after accept", {63'd0, busy}, 64'd1);
    wait_done(ok);
    if (ok) begin
      chk("R8 illegal flag", {63'd0, illegal}, {63'd0, v.ill});
      chk("R4/R5 src write-back enable", {63'd0, wb_src_en}, {63'd0, v.wsrc});
      chk("R6 r0 write-back enable", {63'd0, wb_r0_en}, {63'd0, v.wr0});
      if (v.wsrc || v.wr0) chk("R4/R6/R7 write-back data", wb_data, v.wbd);
      @(negedge clk);
      chk("R10 single done pulse", {62'd0, done, busy}, 64'd0);
    end
    exp_wr = !v.ill && !(v.wr0 && v.mout == v.min);
    chk("R3/R5/R6 memory result", mem[9], v.mout);
    chk("R8/R9 read count", rd_cnt, v.ill ? 0 : 1);
    chk("R6/R8/R9 write count", wr_cnt, exp_wr ? 1 : 0);
    if (!v.ill) begin
      chk("R2 address", last_addr, 64'h48);
      chk("R7 width", {63'd0, last_wide}, {63'd0, v.sz == 2'd3});
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 1'b0; start = 1'b0; slow = 1'b0; clr = 1'b1; pl_en = 1'b0;
    pl_idx = 4'd0; pl_data = 64'd0; base_addr = 64'd0; offset = 16'd0;
    src_val = 64'd0; r0_val = 64'd0; op_size = 2'd0; op_code = 32'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {58'd0, busy, done, illegal, mem_req, wb_src_en, wb_r0_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {58'd0, busy, done, illegal, mem_req, wb_src_en, wb_r0_en}, 64'd0);
    clr = 1'b0;

    for (int m = 0; m < 2; m++) begin
      slow = (m == 1);
      for (int i = 0; i < NV; i++) run_vec(V[i]);
    end

    // R10: start held while busy must not restart
    slow = 1'b0;
    preload(64'd5);
    base_addr = 64'h40; offset = 16'd8; src_val = 64'd3; op_size = 2'd3; op_code = 32'h00;
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 start ignored while busy: writes", wr_cnt, 1);
    chk("R10 start ignored while busy: memory", mem[9], 64'd8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule